// File: doc/BRIEF.md
# Gated Decimal Count Register with Serial Unload

This block is the accumulating register of a frequency counter. A chain of cascaded decimal counters totals input pulses while a measurement gate is open and the mode input selects counting. An external high-speed prescaler resolves the two lowest decimal digits and presents each of them as a 4-bit BCD value. When the gate closes, the block pulls those two digits in one bit per clock through a 2-bit line selector that steps in Gray order. Each bit goes into a dedicated 4-bit shift stage, and those stages sit at the bottom of the same chain.

When the mode input is pulled low, the whole register becomes one long shift register. Every shift strobe moves the complete decimal result one bit toward the serial output, so a downstream stage receives the measurement with the lowest digit first and the lowest bit of each digit first. A clear input prepares the register for a new gate interval. A sticky flag records that the count ran past the top decade.

Top module: `gbcd_count_reg`

## Requirements
- R1: Reset and a one-cycle `clear_i` pulse set every digit to zero and drop `overflow_o`; afterwards an unload shifts out only zeros.
- R2: A cycle with `pulse_i` high adds one to the counted value only when `gate_open_i` and `cnt_mode_i` are both high. A pulse in any other cycle changes nothing.
- R3: Each counting decade runs 0 to 9 and wraps from 9 to 0. The wrap passes a carry into the next higher decade in the same cycle, so the upper decades hold the pulse total modulo 10^NDEC in decimal.
- R4: A carry out of the most significant decade sets `overflow_o`. The flag stays set through later gate intervals and unloads until reset or `clear_i`.
- R5: A high-to-low transition of `gate_open_i` while `cnt_mode_i` is high starts a capture of four consecutive cycles. During those cycles the 2-bit select code takes the values 00, 01, 11, 10 in that order, picking BCD bits 0, 1, 2 and 3 respectively.
- R6: Capture loads the lowest digit from `lsd_lo_i` and the next digit from `lsd_hi_i`, each bit sampled in its capture cycle.
- R7: While `cnt_mode_i` is low, each cycle with `shift_i` high moves the register one bit toward `serial_o`, and `serial_o` always shows bit 0 of the lowest digit. The unload order is bit 0 to bit 3 of the lowest digit, then the next digit upward. Zeros fill in behind, so output bits after the last digit are 0.
- R8: `shift_i` has no effect while `cnt_mode_i` is high, and a falling gate edge while `cnt_mode_i` is low starts no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_i | input | 1 | Zero all digits and the overflow flag |
| cnt_mode_i | input | 1 | High: count and capture; low: serial shift |
| gate_open_i | input | 1 | Measurement gate, high while open |
| pulse_i | input | 1 | One count per cycle in which it is high |
| shift_i | input | 1 | Shift strobe, one bit per cycle in which it is high |
| lsd_lo_i | input | 4 | Lowest digit (10^0) from the prescaler, BCD |
| lsd_hi_i | input | 4 | Second digit (10^1) from the prescaler, BCD |
| serial_o | output | 1 | Serial data, bit 0 of the lowest digit |
| overflow_o | output | 1 | Sticky overflow past the top decade |

## Verification
On every cycle the assertions check these local rules: a decade wraps from 9 to 0, an idle decade keeps its value, the select code changes by exactly one bit per capture step, a capture begins at the select value for bit 0, the overflow flag is sticky, and each shift moves the next bit onto the serial output. Only the bench's scenarios show end-to-end results: a decimal total that crosses decade boundaries, digits captured in the right bit positions, the full unload order with zero fill, and pulses and strobes in the wrong mode leaving the result untouched.

// File: rtl/gbcd_pkg.sv
package gbcd_pkg;

    typedef logic [3:0] bcd_t;

    localparam bcd_t BCD_TOP = 4'd9;

    // Select code for the low-digit line selector, Gray ordered
    typedef enum logic [1:0] {
        SEL_B0 = 2'b00,
        SEL_B1 = 2'b01,
        SEL_B2 = 2'b11,
        SEL_B3 = 2'b10
    } lsd_sel_e;

    // Per-cell control bundle
    typedef struct packed {
        logic clr;
        logic shift;
        logic inc;
        logic sin;
    } dec_ctl_t;

    function automatic lsd_sel_e sel_next(input lsd_sel_e s);
        case (s)
            SEL_B0:  return SEL_B1;
            SEL_B1:  return SEL_B2;
            SEL_B2:  return SEL_B3;
            default: return SEL_B0;
        endcase
    endfunction

    // Gray code to bit index
    function automatic logic [1:0] sel_to_idx(input lsd_sel_e s);
        return {s[1], s[1] ^ s[0]};
    endfunction

    function automatic bcd_t bcd_incr(input bcd_t d);
        return (d == BCD_TOP) ? 4'd0 : d + 4'd1;
    endfunction

endpackage

// File: rtl/gbcd_decade.sv
module gbcd_decade
    import gbcd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  dec_ctl_t ctl_i,
    output bcd_t     digit_o,
    output logic     carry_o
);

    bcd_t digit_q;

    always_ff @(posedge clk) begin
        if (rst || ctl_i.clr) begin
            digit_q <= '0;
        end else if (ctl_i.shift) begin
            digit_q <= {ctl_i.sin, digit_q[3:1]};
        end else if (ctl_i.inc) begin
            digit_q <= bcd_incr(digit_q);
        end
    end

    assign digit_o = digit_q;
    assign carry_o = ctl_i.inc && !ctl_i.shift && !ctl_i.clr && (digit_q == BCD_TOP);

    // R3
    dec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_i.inc && !ctl_i.shift && !ctl_i.clr && digit_q == BCD_TOP) |=> (digit_q == 4'd0));

    // R2
    dec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_i.inc && !ctl_i.shift && !ctl_i.clr) |=> $stable(digit_q));

endmodule

// File: rtl/gbcd_lsd_capture.sv
module gbcd_lsd_capture
    import gbcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr_i,
    input  logic       mode_i,
    input  logic       gate_i,
    input  bcd_t       lo_i,
    input  bcd_t       hi_i,
    output logic       step_o,
    output logic [1:0] bits_o
);

    logic     gate_q;
    logic     active_q;
    lsd_sel_e sel_q;
    logic [1:0] idx;
    logic     gate_fall;

    assign gate_fall = gate_q && !gate_i;

    always_ff @(posedge clk) begin
        if (rst) gate_q <= 1'b0;
        else     gate_q <= gate_i;
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i || !mode_i) begin
            active_q <= 1'b0;
            sel_q    <= SEL_B0;
        end else if (active_q) begin
            if (sel_q == SEL_B3) active_q <= 1'b0;
            sel_q <= sel_next(sel_q);
        end else if (gate_fall) begin
            active_q <= 1'b1;
            sel_q    <= SEL_B0;
        end
    end

    assign idx    = sel_to_idx(sel_q);
    assign step_o = active_q && mode_i && !clr_i;
    assign bits_o = {hi_i[idx], lo_i[idx]};

    // R5
    sel_gray_chk: assert property (@(posedge clk) disable iff (rst)
        (step_o && sel_q != SEL_B3) |=> (active_q && $countones(sel_q ^ $past(sel_q)) == 1));

    // R5
    cap_start_chk: assert property (@(posedge clk) disable iff (rst)
        (!active_q && gate_fall && mode_i && !clr_i) |=> (active_q && sel_q == SEL_B0));

    // R8
    no_cap_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!active_q && !mode_i) |=> !active_q);

endmodule

// File: rtl/gbcd_count_reg.sv
module gbcd_count_reg
    import gbcd_pkg::*;
#(
    parameter int NDEC = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear_i,
    input  logic       cnt_mode_i,
    input  logic       gate_open_i,
    input  logic       pulse_i,
    input  logic       shift_i,
    input  logic [3:0] lsd_lo_i,
    input  logic [3:0] lsd_hi_i,
    output logic       serial_o,
    output logic       overflow_o
);

    localparam int NLSD  = 2;
    localparam int NCELL = NDEC + NLSD;

    bcd_t       digit_w [NCELL];
    logic       carry_w [NCELL];
    dec_ctl_t   ctl_w   [NCELL];
    logic       cnt_inc;
    logic       shift_en;
    logic       cap_step;
    logic [1:0] cap_bits;
    logic       ovf_q;

    assign cnt_inc  = pulse_i && gate_open_i && cnt_mode_i && !clear_i;
    assign shift_en = shift_i && !cnt_mode_i && !clear_i;

    gbcd_lsd_capture u_cap (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (clear_i),
        .mode_i (cnt_mode_i),
        .gate_i (gate_open_i),
        .lo_i   (lsd_lo_i),
        .hi_i   (lsd_hi_i),
        .step_o (cap_step),
        .bits_o (cap_bits)
    );

    for (genvar k = 0; k < NCELL; k++) begin : g_cell
        logic next_bit;

        if (k == NCELL - 1) begin : g_top
            assign next_bit = 1'b0;
        end else begin : g_mid
            assign next_bit = digit_w[k+1][0];
        end

        if (k < NLSD) begin : g_lsd
            assign ctl_w[k].clr   = clear_i;
            assign ctl_w[k].inc   = 1'b0;
            assign ctl_w[k].shift = shift_en || cap_step;
            assign ctl_w[k].sin   = cap_step ? cap_bits[k] : next_bit;
        end else begin : g_cnt
            assign ctl_w[k].clr   = clear_i;
            assign ctl_w[k].shift = shift_en;
            assign ctl_w[k].sin   = next_bit;
            if (k == NLSD) begin : g_first
                assign ctl_w[k].inc = cnt_inc;
            end else begin : g_chain
                assign ctl_w[k].inc = carry_w[k-1];
            end
        end

        gbcd_decade u_dec (
            .clk     (clk),
            .rst     (rst),
            .ctl_i   (ctl_w[k]),
            .digit_o (digit_w[k]),
            .carry_o (carry_w[k])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i)          ovf_q <= 1'b0;
        else if (carry_w[NCELL-1])   ovf_q <= 1'b1;
    end

    assign overflow_o = ovf_q;
    assign serial_o   = digit_w[0][0];

    // R4
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (overflow_o && !clear_i) |=> overflow_o);

    // R1
    clear_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> !overflow_o);

    // R7
    serial_step_chk: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (serial_o == $past(digit_w[0][1])));

    // R8
    no_shift_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_mode_i && !clear_i && !cap_step) |=> $stable(digit_w[0]));

endmodule

// File: tb/gbcd_count_reg_bench.sv
module gbcd_count_reg_bench;

    localparam int NDEC  = 3;
    localparam int NBITS = 4 * (NDEC + 2);
    localparam int EXTRA = 4;
    localparam int MODV  = 1000;
    localparam int NVEC  = 8;

    // {pulse count, low digit, high digit}
    localparam logic [19:0] VEC [NVEC] = '{
        {12'd0,    4'd0, 4'd0},
        {12'd7,    4'd3, 4'd9},
        {12'd10,   4'd5, 4'd1},
        {12'd99,   4'd0, 4'd8},
        {12'd123,  4'd4, 4'd6},
        {12'd999,  4'd2, 4'd7},
        {12'd1000, 4'd9, 4'd0},
        {12'd1005, 4'd1, 4'd1}
    };

    logic clk = 1'b0;
    logic rst, clear_i, cnt_mode_i, gate_open_i, pulse_i, shift_i;
    logic [3:0] lsd_lo_i, lsd_hi_i;
    logic serial_o, overflow_o;

    int tests  = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    gbcd_count_reg #(.NDEC(NDEC)) u_gbcd_count_reg (
        .clk         (clk),
        .rst         (rst),
        .clear_i     (clear_i),
        .cnt_mode_i  (cnt_mode_i),
        .gate_open_i (gate_open_i),
        .pulse_i     (pulse_i),
        .shift_i     (shift_i),
        .lsd_lo_i    (lsd_lo_i),
        .lsd_hi_i    (lsd_hi_i),
        .serial_o    (serial_o),
        .overflow_o  (overflow_o)
    );

    function automatic logic [NBITS+EXTRA-1:0] exp_word(input int n, input logic [3:0] lo,
                                                      input logic [3:0] hi);
        logic [NBITS+EXTRA-1:0] w;
        int m;
        m = n % MODV;
        w = '0;
        w[3:0] = lo;
        w[7:4] = hi;
        for (int d = 0; d < NDEC; d++) begin
            w[8 + 4*d +: 4] = 4'(m % 10);
            m = m / 10;
        end
        return w;
    endfunction

    task automatic check_bit(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic check_word(input string req, input logic [NBITS+EXTRA-1:0] act,
                              input logic [NBITS+EXTRA-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic unload(input bit junk, output logic [NBITS+EXTRA-1:0] w);
        cnt_mode_i = 1'b0;
        if (junk) begin
            gate_open_i = 1'b1;
            pulse_i     = 1'b1;
        end
        for (int i = 0; i < NBITS + EXTRA; i++) begin
            w[i]    = serial_o;
            shift_i = 1'b1;
            @(negedge clk);
        end
        shift_i     = 1'b0;
        gate_open_i = 1'b0;
        pulse_i     = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_clear();
        clear_i = 1'b1;
        @(negedge clk);
        clear_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic run(input int n, input logic [3:0] lo, input logic [3:0] hi,
                       input bit clr, input bit junk, input logic exp_ovf,
                       input int exp_n, input string req);
        logic [NBITS+EXTRA-1:0] w;
        if (clr) do_clear();
        lsd_lo_i   = lo;
        lsd_hi_i   = hi;
        cnt_mode_i = 1'b1;
        if (junk) begin
            // R2: pulses with the gate closed
            pulse_i = 1'b1;
            repeat (5) @(negedge clk);
            pulse_i = 1'b0;
        end
        gate_open_i = 1'b1;
        shift_i     = junk;   // R8: strobes in count mode
        @(negedge clk);
        pulse_i = (n > 0);
        repeat (n) @(negedge clk);
        pulse_i     = 1'b0;
        gate_open_i = 1'b0;
        shift_i     = 1'b0;
        repeat (8) @(negedge clk);
        check_bit({req, " R4 overflow"}, overflow_o, exp_ovf);
        unload(junk, w);
        check_word({req, " R3/R5/R6/R7 unload"}, w, exp_word(exp_n, lo, hi));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [NBITS+EXTRA-1:0] w;
        rst = 1'b1; clear_i = 1'b0; cnt_mode_i = 1'b0; gate_open_i = 1'b0;
        pulse_i = 1'b0; shift_i = 1'b0; lsd_lo_i = '0; lsd_hi_i = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check_bit("R1 reset overflow", overflow_o, 1'b0);
        unload(1'b0, w);
        check_word("R1 reset unload", w, '0);

        for (int v = 0; v < NVEC; v++) begin
            int n;
            n = int'(VEC[v][19:8]);
            run(n, VEC[v][7:4], VEC[v][3:0], 1'b1, 1'b0, logic'(n >= MODV), n, "vector");
        end

        // R2/R8: stray pulses and strobes in the wrong mode
        run(37, 4'd6, 4'd2, 1'b1, 1'b1, 1'b0, 37, "R2/R8 junk");

        // R4: overflow then a new interval without clear
        run(1003, 4'd1, 4'd2, 1'b1, 1'b0, 1'b1, 1003, "R4 wrap");
        run(5, 4'd3, 4'd3, 1'b0, 1'b0, 1'b1, 5, "R4 sticky");

        // R1: clear drops the flag
        do_clear();
        check_bit("R1 clear overflow", overflow_o, 1'b0);
        unload(1'b0, w);
        check_word("R1 clear unload", w, '0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule